// File: doc/BRIEF.md
# Machine Trap Entry and Return Controller

This block decides when a small 32-bit core must leave its normal instruction flow for a handler, and how it comes back. Each cycle it looks at a vector of interrupt lines, a synchronous exception request with its code, and an exception-return strobe. When it takes a trap, it pulses a take signal with a 6-bit cause. In the same edge it records the current program counter, moves the live status into a shadow copy and clears the global interrupt enable. On a return it pulses a return signal, offers the saved program counter as the redirect target and copies the shadow status back.

Software reaches the live status, the shadow status and the saved program counter through a simple CSR-style port. The port has a write strobe, a 12-bit address, write data and a registered read result. The block never nests on its own. A trap taken inside a handler overwrites the saved registers, so a handler that wants to allow nesting must first store them elsewhere.

Top module: `trap_ctrl`

## Requirements
- R1: After reset, the enable output is 0. The take and return pulses are 0, the cause is 0 and the return target is 0. The status word reads 0x00000006.
- R2: When several interrupt lines are high in the same cycle and the enable is 1, the lowest-numbered line is taken. The cause is then bit 5 set and the line number in bits 4:0.
- R3: Interrupt lines have no effect while the enable is 0. No take pulse appears and the cause keeps its previous value.
- R4: A synchronous exception request wins over any pending interrupt. It is taken even when the enable is 0, with cause bit 5 clear and the exception code in bits 4:0.
- R5: A request sampled at a clock edge gives a one-cycle take pulse after that edge. In the same edge the saved program counter takes the current PC, the shadow enable takes the live enable and the live enable becomes 0.
- R6: A return strobe sampled at an edge gives a one-cycle return pulse after that edge. The return target equals the saved program counter, and the live enable takes the shadow enable.
- R7: The status word (address 0x300) and the shadow word (address 0x7C0) read as bits 31:3 zero, bits 2:1 fixed at 2'b11 and the enable bit at position 0. Only bit 0 is writable.
- R8: The saved program counter is read and written as a full 32-bit word at address 0x341. Read data appears the cycle after the address is presented. Other addresses read 0, and writes to them change no register.
- R9: When a trap and a CSR write to the saved PC, status or shadow fall in the same cycle, the trap values are stored.
- R10: A trap taken inside a handler overwrites the saved program counter and the shadow status, whose enable then becomes 0.
- R11: When a trap and a return strobe fall in the same cycle, only the trap happens and no return pulse is given. When a return and a CSR write to status fall in the same cycle, the restored value is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_lines | input | NUM_IRQ | Interrupt request lines, line 0 has highest priority |
| exc_req | input | 1 | Synchronous exception request |
| exc_code | input | CODE_W | Exception code for the request |
| pc_now | input | XLEN | Address of the instruction being decoded |
| ret_req | input | 1 | Exception-return strobe |
| csr_we | input | 1 | CSR write strobe |
| csr_addr | input | 12 | CSR address |
| csr_wdata | input | XLEN | CSR write data |
| csr_rdata | output | XLEN | Registered CSR read data |
| irq_en | output | 1 | Live global interrupt enable |
| trap_take | output | 1 | One-cycle pulse, a trap was taken |
| trap_cause | output | CODE_W+1 | Cause of the latest trap |
| ret_take | output | 1 | One-cycle pulse, a return was taken |
| ret_pc | output | XLEN | Return target (saved program counter) |

## Verification
The bench raises several interrupt lines together and checks that the lowest one is taken. A reversed or highest-first priority shows up as a wrong cause. It holds lines high while the enable is clear, where a design that ignores the enable would produce a take pulse. It collides traps with CSR writes and with return strobes, because a design with the wrong write order stores the software value or gives both pulses. It nests a second exception inside a handler to prove the shadow status is overwritten with the cleared enable. A design that kept the first saved copy would return with interrupts still enabled.

// File: rtl/trap_pkg.sv
package trap_pkg;
  localparam int CSR_AW = 12;
  localparam logic [CSR_AW-1:0] ADR_STATUS = 12'h300;
  localparam logic [CSR_AW-1:0] ADR_EPC    = 12'h341;
  localparam logic [CSR_AW-1:0] ADR_SHADOW = 12'h7C0;
  localparam logic [1:0]        PRIV_MACH  = 2'b11;

  function automatic logic [31:0] status_word(input logic en);
    return {29'b0, PRIV_MACH, en};
  endfunction
endpackage

// File: rtl/trap_arbiter.sv
module trap_arbiter #(
  parameter int NUM_IRQ = 16,
  parameter int CODE_W  = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_IRQ-1:0] irq_lines,
  input  logic              irq_en,
  input  logic              exc_req,
  input  logic [CODE_W-1:0] exc_code,
  output logic              fire,
  output logic [CODE_W:0]   cause
);
  logic [NUM_IRQ:0]   below;
  logic [NUM_IRQ-1:0] grant;
  logic [CODE_W-1:0]  irq_idx;
  logic               irq_any;

  assign below[0] = 1'b0;
  for (genvar i = 0; i < NUM_IRQ; i++) begin : g_chain
    assign grant[i]   = irq_lines[i] & ~below[i];
    assign below[i+1] = below[i] | irq_lines[i];
  end

  always_comb begin
    irq_idx = '0;
    for (int i = 0; i < NUM_IRQ; i++)
      if (grant[i]) irq_idx = CODE_W'(i);
  end

  assign irq_any = below[NUM_IRQ] & irq_en;
  assign fire    = exc_req | irq_any;
  assign cause   = exc_req ? {1'b0, exc_code} : {1'b1, irq_idx};

  // R2
  irq_grant_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant) && ((|grant) == (|irq_lines)));
  // R3
  irq_masked_chk: assert property (@(posedge clk) disable iff (rst)
    (fire && !exc_req) |-> irq_en);
  // R4
  exc_first_chk: assert property (@(posedge clk) disable iff (rst)
    exc_req |-> (fire && !cause[CODE_W]));
endmodule

// File: rtl/trap_csr_file.sv
module trap_csr_file
  import trap_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              trap_fire,
  input  logic              ret_fire,
  input  logic [XLEN-1:0]   pc_now,
  input  logic              csr_we,
  input  logic [CSR_AW-1:0] csr_addr,
  input  logic [XLEN-1:0]   csr_wdata,
  output logic [XLEN-1:0]   csr_rdata,
  output logic              live_en,
  output logic [XLEN-1:0]   epc
);
  logic live_q, live_d, shadow_q, shadow_d;
  logic [XLEN-1:0] epc_q, epc_d, rd_d;

  always_comb begin
    live_d   = live_q;
    shadow_d = shadow_q;
    epc_d    = epc_q;
    if (csr_we) begin
      unique case (csr_addr)
        ADR_STATUS: live_d   = csr_wdata[0];
        ADR_SHADOW: shadow_d = csr_wdata[0];
        ADR_EPC:    epc_d    = csr_wdata;
        default: ;
      endcase
    end
    if (trap_fire) begin
      epc_d    = pc_now;
      shadow_d = live_q;
      live_d   = 1'b0;
    end else if (ret_fire) begin
      live_d = shadow_q;
    end
  end

  always_comb begin
    unique case (csr_addr)
      ADR_STATUS: rd_d = XLEN'(status_word(live_q));
      ADR_SHADOW: rd_d = XLEN'(status_word(shadow_q));
      ADR_EPC:    rd_d = epc_q;
      default:    rd_d = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      live_q    <= 1'b0;
      shadow_q  <= 1'b0;
      epc_q     <= '0;
      csr_rdata <= '0;
    end else begin
      live_q    <= live_d;
      shadow_q  <= shadow_d;
      epc_q     <= epc_d;
      csr_rdata <= rd_d;
    end
  end

  assign live_en = live_q;
  assign epc     = epc_q;

  // R5
  entry_save_chk: assert property (@(posedge clk) disable iff (rst)
    trap_fire |=> (epc_q == $past(pc_now)) && !live_q && (shadow_q == $past(live_q)));
  // R6
  return_restore_chk: assert property (@(posedge clk) disable iff (rst)
    (ret_fire && !trap_fire) |=> (live_q == $past(shadow_q)));
endmodule

// File: rtl/trap_ctrl.sv
module trap_ctrl
  import trap_pkg::*;
#(
  parameter int NUM_IRQ = 16,
  parameter int CODE_W  = 5,
  parameter int XLEN    = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_IRQ-1:0] irq_lines,
  input  logic               exc_req,
  input  logic [CODE_W-1:0]  exc_code,
  input  logic [XLEN-1:0]    pc_now,
  input  logic               ret_req,
  input  logic               csr_we,
  input  logic [11:0]        csr_addr,
  input  logic [XLEN-1:0]    csr_wdata,
  output logic [XLEN-1:0]    csr_rdata,
  output logic               irq_en,
  output logic               trap_take,
  output logic [CODE_W:0]    trap_cause,
  output logic               ret_take,
  output logic [XLEN-1:0]    ret_pc
);
  logic            fire;
  logic [CODE_W:0] cause_d;
  logic            ret_ok;

  trap_arbiter #(.NUM_IRQ(NUM_IRQ), .CODE_W(CODE_W)) u_arb (
    .clk(clk), .rst(rst), .irq_lines(irq_lines), .irq_en(irq_en),
    .exc_req(exc_req), .exc_code(exc_code), .fire(fire), .cause(cause_d)
  );

  assign ret_ok = ret_req & ~fire;

  trap_csr_file #(.XLEN(XLEN)) u_csr (
    .clk(clk), .rst(rst), .trap_fire(fire), .ret_fire(ret_ok),
    .pc_now(pc_now), .csr_we(csr_we), .csr_addr(csr_addr),
    .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .live_en(irq_en),
    .epc(ret_pc)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      trap_take  <= 1'b0;
      ret_take   <= 1'b0;
      trap_cause <= '0;
    end else begin
      trap_take <= fire;
      ret_take  <= ret_ok;
      if (fire) trap_cause <= cause_d;
    end
  end

  // R11
  no_double_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    !(trap_take && ret_take));
  // R5
  entry_disables_chk: assert property (@(posedge clk) disable iff (rst)
    trap_take |-> !irq_en);
  // R3
  masked_stays_chk: assert property (@(posedge clk) disable iff (rst)
    (!irq_en && !exc_req) |=> !trap_take && $stable(trap_cause));
endmodule

// File: tb/sim_trap_ctrl.sv
module sim_trap_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int NI = 16;

  logic clk = 0, rst = 1;
  logic [NI-1:0] irq_lines = '0;
  logic exc_req = 0, ret_req = 0, csr_we = 0;
  logic [4:0] exc_code = '0;
  logic [31:0] pc_now = '0, csr_wdata = '0, csr_rdata, ret_pc;
  logic [11:0] csr_addr = '0;
  logic irq_en, trap_take, ret_take;
  logic [5:0] trap_cause;
  int checks = 0, fails = 0;
  logic [31:0] rv;

  trap_ctrl u0 (.clk(clk), .rst(rst), .irq_lines(irq_lines), .exc_req(exc_req),
    .exc_code(exc_code), .pc_now(pc_now), .ret_req(ret_req), .csr_we(csr_we),
    .csr_addr(csr_addr), .csr_wdata(csr_wdata), .csr_rdata(csr_rdata),
    .irq_en(irq_en), .trap_take(trap_take), .trap_cause(trap_cause),
    .ret_take(ret_take), .ret_pc(ret_pc));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic csr_wr(input logic [11:0] a, input logic [31:0] d);
    csr_we = 1; csr_addr = a; csr_wdata = d;
    @(negedge clk);
    csr_we = 0;
  endtask

  task automatic csr_rd(input logic [11:0] a, output logic [31:0] d);
    csr_addr = a;
    @(negedge clk);
    d = csr_rdata;
  endtask

  task automatic clear_in();
    irq_lines = '0; exc_req = 0; ret_req = 0; csr_we = 0;
  endtask

  task automatic t_reset();
    chk("R1 irq_en", {31'b0, irq_en}, 0);
    chk("R1 trap_take", {31'b0, trap_take}, 0);
    chk("R1 ret_take", {31'b0, ret_take}, 0);
    chk("R1 cause", {26'b0, trap_cause}, 0);
    chk("R1 ret_pc", ret_pc, 0);
    csr_rd(12'h300, rv); chk("R1 status read", rv, 32'h6);
  endtask

  task automatic t_masked();
    irq_lines = 16'h0010;
    @(negedge clk);
    chk("R3 no take while disabled", {31'b0, trap_take}, 0);
    @(negedge clk);
    chk("R3 cause unchanged", {26'b0, trap_cause}, 0);
    clear_in();
  endtask

  task automatic t_priority();
    csr_wr(12'h300, 32'h1);
    chk("R8 enable written", {31'b0, irq_en}, 1);
    irq_lines = 16'h0828; pc_now = 32'h100;
    @(negedge clk); clear_in();
    chk("R5 take pulse", {31'b0, trap_take}, 1);
    chk("R2 lowest line cause", {26'b0, trap_cause}, 32'h23);
    chk("R5 enable cleared", {31'b0, irq_en}, 0);
    @(negedge clk);
    chk("R5 pulse one cycle", {31'b0, trap_take}, 0);
    csr_rd(12'h7C0, rv); chk("R5 shadow holds enable", rv, 32'h7);
    csr_rd(12'h341, rv); chk("R8 saved pc read", rv, 32'h100);
  endtask

  task automatic t_return();
    ret_req = 1;
    @(negedge clk); clear_in();
    chk("R6 return pulse", {31'b0, ret_take}, 1);
    chk("R6 return target", ret_pc, 32'h100);
    chk("R6 enable restored", {31'b0, irq_en}, 1);
    @(negedge clk);
    chk("R6 pulse one cycle", {31'b0, ret_take}, 0);
  endtask

  task automatic t_exc_first();
    irq_lines = 16'h0001; exc_req = 1; exc_code = 5'd2; pc_now = 32'h200;
    @(negedge clk); clear_in();
    chk("R4 exception cause", {26'b0, trap_cause}, 32'h02);
    chk("R4 take pulse", {31'b0, trap_take}, 1);
    chk("R5 epc", ret_pc, 32'h200);
  endtask

  task automatic t_nested();
    exc_req = 1; exc_code = 5'd11; pc_now = 32'h300;
    @(negedge clk); clear_in();
    chk("R10 cause", {26'b0, trap_cause}, 32'h0B);
    chk("R10 epc overwritten", ret_pc, 32'h300);
    csr_rd(12'h7C0, rv); chk("R10 shadow overwritten", rv, 32'h6);
    ret_req = 1;
    @(negedge clk); clear_in();
    chk("R10 return keeps disabled", {31'b0, irq_en}, 0);
  endtask

  task automatic t_trap_vs_write();
    exc_req = 1; exc_code = 5'd4; pc_now = 32'h400;
    csr_we = 1; csr_addr = 12'h341; csr_wdata = 32'hDEAD_BEEF;
    @(negedge clk); clear_in();
    chk("R9 epc from trap", ret_pc, 32'h400);
    csr_wr(12'h300, 32'h1);
    exc_req = 1; pc_now = 32'h404;
    csr_we = 1; csr_addr = 12'h300; csr_wdata = 32'h1;
    @(negedge clk); clear_in();
    chk("R9 status from trap", {31'b0, irq_en}, 0);
  endtask

  task automatic t_trap_vs_ret();
    exc_req = 1; ret_req = 1; pc_now = 32'h500;
    @(negedge clk); clear_in();
    chk("R11 trap taken", {31'b0, trap_take}, 1);
    chk("R11 no return", {31'b0, ret_take}, 0);
    chk("R11 epc", ret_pc, 32'h500);
    csr_wr(12'h7C0, 32'h1);
    ret_req = 1; csr_we = 1; csr_addr = 12'h300; csr_wdata = 32'h0;
    @(negedge clk); clear_in();
    chk("R11 restore beats write", {31'b0, irq_en}, 1);
  endtask

  task automatic t_layout();
    csr_wr(12'h300, 32'hFFFF_FFFF);
    csr_rd(12'h300, rv); chk("R7 status layout set", rv, 32'h7);
    csr_wr(12'h7C0, 32'hFFFF_FFF8);
    csr_rd(12'h7C0, rv); chk("R7 shadow layout clear", rv, 32'h6);
    csr_wr(12'h300, 32'h0);
    csr_rd(12'h300, rv); chk("R7 status cleared", rv, 32'h6);
  endtask

  task automatic t_unmapped();
    csr_wr(12'h341, 32'h1234_5678);
    csr_wr(12'h123, 32'hFFFF_FFFF);
    csr_rd(12'h123, rv); chk("R8 unmapped reads zero", rv, 0);
    csr_rd(12'h341, rv); chk("R8 epc untouched", rv, 32'h1234_5678);
    csr_rd(12'h300, rv); chk("R8 status untouched", rv, 32'h6);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_masked();
    t_priority();
    t_return();
    t_exc_first();
    t_nested();
    t_trap_vs_write();
    t_trap_vs_ret();
    t_layout();
    t_unmapped();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule